// File: doc/BRIEF.md
# Timeout-Guarded Byte-Grouping Serial Word Receiver

This block takes one serial data line and a bit clock that both come from outside, and turns the stream into parallel words. Both lines pass through a synchroniser into the system clock domain. Each rising edge of the bit clock takes one data bit. The bits are packed least significant bit first into bytes. A word assembler then joins one to four bytes into a word of 8, 16, 24 or 32 bits. The number of bytes is chosen at run time through a two-bit select. Each finished word appears for one system-clock cycle with a valid strobe.

A watchdog counts system clocks from each re-arm point. Its limit is sixteen bit-clock half-periods per configured byte, plus a jitter margin. Both the half-period and the margin are parameters. If the whole word has not arrived when the limit runs out, the watchdog drops the partial word and pulses a timeout output. Incoming bytes do not restart the watchdog. It is re-armed only after a finished word or after a timeout. The receiver has no frame alignment. The bit packer is never cleared, so bits left over from an interrupted transfer shift every later byte.

The assembler is a four-state machine:
- LOAD latches the width select, loads the watchdog limit and clears the byte counter and accumulator. It always moves to COLLECT.
- COLLECT ORs bytes into the accumulator and counts the watchdog down. It moves to EXPIRE when the count is zero; this takes priority over a byte arriving in the same cycle. It moves to DONE when the last byte of the word arrives. Otherwise it stays in COLLECT.
- DONE presents the word and moves to LOAD.
- EXPIRE raises the timeout and moves to LOAD.

Top module: `sdes_word_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `word_valid` and `word_timeout` are 0 and `word_data` is 0.
- R2: A data bit is taken at each rising edge of `bclk_in`. Within each byte, the first bit received lands in bit 0 and the eighth in bit 7.
- R3: `width_sel` codes 0, 1, 2 and 3 select 1, 2, 3 and 4 bytes per word. Byte k of a word (counting from 0) occupies `word_data[8k+7:8k]`. All bits above the selected width are 0.
- R4: `word_valid` is high for exactly one cycle per word and never in the same cycle as `word_timeout`. `word_data` is 0 whenever `word_valid` is low.
- R5: With L = 16 × bytes × HALF_CYC + JITTER_CYC, `word_timeout` pulses for one cycle exactly L+3 cycles after the last `word_valid` or `word_timeout` pulse, if no word completes in between. L uses the width latched at that re-arm.
- R6: Bytes that arrive without completing a word do not delay the timeout. It still comes L+3 cycles after the previous re-arm event.
- R7: A timeout discards the partly built word and emits no word. The next word holds only bytes received after the timeout.
- R8: `width_sel` is latched only when the assembler re-arms after a word or a timeout. A change in the middle of a word does not alter that word's width.
- R9: A timeout does not clear the bit packer. Bits received before a timeout combine with later bits into the next byte.
- R10: The first word after reset is one byte long, whatever the value of `width_sel`. The select is first taken at the first re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | External bit clock, asynchronous to `clk` |
| bdat_in | input | 1 | Serial data, valid at the rising edge of `bclk_in` |
| width_sel | input | 2 | Bytes per word minus one |
| word_data | output | 32 | Assembled word, zero outside the valid cycle |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_timeout | output | 1 | One-cycle strobe when the watchdog expires |

## Verification
The word path is tried with every width code. The patterns use asymmetric byte values, so a byte-order swap or a bit reversal inside a byte produces a wrong word, and sparse words such as 0x00000001 show leakage into unused lanes. Timeout spacing is measured after every table word, and after a stall that follows a partial word; this separates a watchdog that is restarted per byte from one that is re-armed per word. Directed sequences change the width in the middle of a word and stall after half a byte. These separate latching at re-arm from latching at once, and a bit packer that is kept from one that is cleared.

// File: rtl/sdes_pkg.sv
package sdes_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2,
        ST_EXPIRE  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/sdes_sync_vec.sv
module sdes_sync_vec #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sdes_byte_pack.sv
module sdes_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              bdat_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              bclk_d;
    logic              rise;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_n;
    logic [CNT_W-1:0]  bit_cnt;

    assign rise    = bclk_s & ~bclk_d;
    assign shift_n = {bdat_s, shift_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d    <= 1'b0;
            shift_q   <= '0;
            bit_cnt   <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            bclk_d   <= bclk_s;
            byte_vld <= 1'b0;
            if (rise) begin
                shift_q <= shift_n;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_vld  <= 1'b1;
                    byte_data <= shift_n;
                end
            end
        end
    end
endmodule

// File: rtl/sdes_word_fsm.sv
module sdes_word_fsm
    import sdes_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int MAX_BYTES  = 4,
    parameter int HALF_CYC   = 8,
    parameter int JITTER_CYC = 64,
    localparam int SEL_W     = $clog2(MAX_BYTES),
    localparam int WORD_W    = BYTE_W * MAX_BYTES,
    localparam int TMR_MAX   = 2 * BYTE_W * MAX_BYTES * HALF_CYC + JITTER_CYC,
    localparam int TMR_W     = $clog2(TMR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [SEL_W-1:0]  width_s,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              word_timeout,
    output logic [SEL_W-1:0]  len_q,
    output rx_state_e         state_q
);
    rx_state_e         state_n;
    logic [TMR_W-1:0]  tmr_q;
    logic [SEL_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_n;
    logic              expired;
    logic              last_byte;

    function automatic logic [TMR_W-1:0] limit_for(input logic [SEL_W-1:0] code);
        int unsigned v;
        v = 2 * BYTE_W * (int'(code) + 1) * HALF_CYC + JITTER_CYC;
        return TMR_W'(v);
    endfunction

    assign expired   = (tmr_q == '0);
    assign last_byte = byte_vld && (cnt_q == len_q);

    generate
        for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
            always_comb begin
                acc_n[k*BYTE_W +: BYTE_W] = acc_q[k*BYTE_W +: BYTE_W];
                if (byte_vld && (cnt_q == SEL_W'(k)))
                    acc_n[k*BYTE_W +: BYTE_W] = acc_q[k*BYTE_W +: BYTE_W] | byte_data;
            end
        end
    endgenerate

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_LOAD:    state_n = ST_COLLECT;
            ST_COLLECT: begin
                if (expired)        state_n = ST_EXPIRE;
                else if (last_byte) state_n = ST_DONE;
            end
            ST_DONE:    state_n = ST_LOAD;
            ST_EXPIRE:  state_n = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            tmr_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    len_q <= width_s;
                    tmr_q <= limit_for(width_s);
                    cnt_q <= '0;
                    acc_q <= '0;
                end
                ST_COLLECT: begin
                    if (!expired) begin
                        tmr_q <= tmr_q - 1'b1;
                        if (byte_vld) begin
                            acc_q <= acc_n;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_DONE:   ;
                ST_EXPIRE: acc_q <= '0;
            endcase
        end
    end

    always_comb begin
        word_valid   = 1'b0;
        word_timeout = 1'b0;
        word_data    = '0;
        unique case (state_q)
            ST_DONE: begin
                word_valid = 1'b1;
                word_data  = acc_q;
            end
            ST_EXPIRE:  word_timeout = 1'b1;
            ST_LOAD:    ;
            ST_COLLECT: ;
        endcase
    end
endmodule

// File: rtl/sdes_word_rx.sv
module sdes_word_rx
    import sdes_pkg::*;
#(
    parameter int HALF_CYC    = 8,
    parameter int JITTER_CYC  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = 8,
    localparam int MAX_BYTES  = 4,
    localparam int SEL_W      = $clog2(MAX_BYTES),
    localparam int WORD_W     = BYTE_W * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              bdat_in,
    input  logic [SEL_W-1:0]  width_sel,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              word_timeout
);
    logic              bclk_s;
    logic              bdat_s;
    logic [SEL_W-1:0]  width_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic [SEL_W-1:0]  len_q;
    rx_state_e         state_q;
    logic [SEL_W+1:0]  sync_out;

    sdes_sync_vec #(.W(SEL_W + 2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({width_sel, bdat_in, bclk_in}),
        .d_out (sync_out)
    );
    assign {width_s, bdat_s, bclk_s} = sync_out;

    sdes_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (bclk_s),
        .bdat_s    (bdat_s),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    sdes_word_fsm #(
        .BYTE_W     (BYTE_W),
        .MAX_BYTES  (MAX_BYTES),
        .HALF_CYC   (HALF_CYC),
        .JITTER_CYC (JITTER_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .width_s      (width_s),
        .word_data    (word_data),
        .word_valid   (word_valid),
        .word_timeout (word_timeout),
        .len_q        (len_q),
        .state_q      (state_q)
    );
endmodule

// File: rtl/sdes_word_rx_chk.sv
module sdes_word_rx_chk
    import sdes_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] word_data,
    input logic        word_valid,
    input logic        word_timeout,
    input logic [1:0]  len_q,
    input rx_state_e   state_q
);
    logic [63:0] data_ext;
    assign data_ext = {32'd0, word_data};

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && word_timeout)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R4
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (word_data == 32'd0)); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((data_ext >> (8 * (int'(len_q) + 1))) == 64'd0)); // R3
    AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_timeout |=> !word_timeout); // R5
    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD) |=> $stable(len_q)); // R8
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid || word_timeout) |=> (state_q == ST_LOAD)); // R7
endmodule

bind sdes_word_rx sdes_word_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_data    (word_data),
    .word_valid   (word_valid),
    .word_timeout (word_timeout),
    .len_q        (len_q),
    .state_q      (state_q)
);

// File: tb/sdes_word_rx_bench.sv
module sdes_word_rx_bench;
    localparam int HALF = 4;
    localparam int JIT  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        bdat_in = 1'b0;
    logic [1:0]  width_sel = 2'd3;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_timeout;

    int cyc = 0;
    int n_word = 0, n_tmo = 0, t_word = 0, t_tmo = 0;
    logic [31:0] last_word = '0;
    int checks = 0, fails = 0;

    // 8 entries: {width code, expected word}
    localparam logic [33:0] VEC [8] = '{
        {2'd0, 32'h0000_003C}, {2'd1, 32'h0000_BEEF},
        {2'd2, 32'h0012_3456}, {2'd3, 32'hF0A0_5030},
        {2'd3, 32'h0000_0001}, {2'd1, 32'h0000_8001},
        {2'd0, 32'h0000_00FF}, {2'd2, 32'h00A5_5AC3}
    };

    always #10 clk = ~clk;

    sdes_word_rx #(.HALF_CYC(HALF), .JITTER_CYC(JIT)) u_sdes_word_rx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .bdat_in(bdat_in),
        .width_sel(width_sel), .word_data(word_data),
        .word_valid(word_valid), .word_timeout(word_timeout)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (word_valid) begin
            n_word++; last_word = word_data; t_word = cyc;
        end
        if (word_timeout) begin
            n_tmo++; t_tmo = cyc;
        end
    end

    function automatic int lim(input int code);
        return 16 * (code + 1) * HALF + JIT;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bdat_in = b; bclk_in = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        @(negedge clk); bclk_in = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic wait_word(input int prev);
        for (int k = 0; k < 4000 && n_word == prev; k++) @(negedge clk);
    endtask

    task automatic wait_tmo(input int prev);
        for (int k = 0; k < 4000 && n_tmo == prev; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int pw, pt, t0;
        int prev_code;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1 valid", {31'd0, word_valid}, 32'd0);
        chk("R1 timeout", {31'd0, word_timeout}, 32'd0);
        chk("R1 data", word_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after release", word_data, 32'd0);

        // R10: width code 3 applied, first word still one byte
        pw = n_word;
        send_bits(8'hA5, 8);
        wait_word(pw);
        chk("R10 first word one byte", last_word, 32'h0000_00A5);

        // Table: R2 R3 data, R5 spacing
        prev_code = 0;
        for (int i = 0; i < 8; i++) begin
            width_sel = VEC[i][33:32];
            pt = n_tmo;
            wait_tmo(pt);
            if (i > 0)
                chk("R5 timeout spacing", 32'(t_tmo - t_word), 32'(lim(prev_code) + 3));
            pw = n_word;
            for (int b = 0; b <= int'(VEC[i][33:32]); b++)
                send_bits(VEC[i][8*b +: 8], 8);
            wait_word(pw);
            chk("R2 R3 word", last_word, VEC[i][31:0]);
            prev_code = int'(VEC[i][33:32]);
        end

        // R6 R7: partial word, then stall
        width_sel = 2'd2;
        pt = n_tmo; wait_tmo(pt);
        pt = n_tmo; wait_tmo(pt);
        t0 = t_tmo;
        pw = n_word; pt = n_tmo;
        send_bits(8'h11, 8);
        wait_tmo(pt);
        chk("R6 timeout not restarted by byte", 32'(t_tmo - t0), 32'(lim(2) + 3));
        chk("R7 no word on timeout", 32'(n_word), 32'(pw));
        send_bits(8'h21, 8); send_bits(8'h32, 8); send_bits(8'h43, 8);
        wait_word(pw);
        chk("R7 only new bytes", last_word, 32'h0043_3221);

        // R8: mid-word width change
        width_sel = 2'd1;
        pt = n_tmo; wait_tmo(pt);
        pt = n_tmo; wait_tmo(pt);
        pw = n_word;
        send_bits(8'h5A, 8);
        width_sel = 2'd0;
        send_bits(8'hC3, 8);
        wait_word(pw);
        chk("R8 width held mid word", last_word, 32'h0000_C35A);
        pw = n_word;
        send_bits(8'h77, 8);
        wait_word(pw);
        chk("R8 new width at rearm", last_word, 32'h0000_0077);

        // R9: half byte, stall, packer keeps its bits
        pt = n_tmo; wait_tmo(pt);
        pw = n_word;
        send_bits(8'h0B, 4);
        pt = n_tmo; wait_tmo(pt);
        chk("R9 no word from half byte", 32'(n_word), 32'(pw));
        send_bits(8'h5E, 8);
        wait_word(pw);
        chk("R9 shifted byte", last_word, 32'h0000_00EB);
        pw = n_word;
        send_bits(8'h00, 4);
        wait_word(pw);
        chk("R9 leftover nibble", last_word, 32'h0000_0005);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule